// File: doc/BRIEF.md
# Processor-Side Register Port for a Two-Wire Serial Controller

This block connects a byte-wide processor bus to a two-wire serial controller. The processor bus is asynchronous and uses strobes. The block holds four byte registers for the controller: its own bus address, a control byte, a status byte and a data byte. The processor starts an access by pulling the address strobe and the data strobe low. It uses a read/write line to choose the direction, with high meaning read. It waits for the active-low acknowledge and then releases both strobes. The block drops the acknowledge again once the strobes are seen high.

The upper sixteen address bits must equal the `BASE` parameter. The low address byte then picks the register. On a read, the block drives the shared data bus only while the access is acknowledged; at all other times it leaves the bus floating. On the serial side, the block presents the control, own-address and transmit bytes to the bit engine and pulses a strobe whenever the processor writes the data byte. It takes from the engine the status flags, a received byte with its load strobe, and a request to flag an interrupt.

Top module: `mpu_reg_port`

## Requirements
- R1: An access is decoded only when `addr_i[23:8]` equals `BASE` (default 0x0000). Low byte 0x8D is the own-address register, 0x91 is control, 0x93 is status and 0x95 is data. Any other address still gets an acknowledge, reads back 0x00 and changes no register.
- R2: `ack_n` falls on the third rising clock edge after both strobes are driven low. It rises on the third rising edge after both strobes are driven high. The strobes pass through two synchronising flops before they are used.
- R3: With `rw` low, each access writes the selected register exactly once. The write happens on the clock edge where `ack_n` falls.
- R4: Control byte layout: bit 7 enable, bit 6 interrupt enable, bit 5 master/start, bit 4 transmit, bit 3 acknowledge to send, bit 2 repeated start. Bits 1:0 are reserved, read as 0 and ignore writes. The stored byte appears on `ctl_o`.
- R5: Status byte layout: bit 7 transfer complete, bit 6 addressed as slave, bit 5 bus busy, bit 4 arbitration lost, bit 3 reserved (reads 0), bit 2 slave read/write, bit 1 interrupt pending, bit 0 received acknowledge. Bits 7:4, 2 and 0 read the live `stat_i` bits of the same positions, and bus writes cannot change them.
- R6: The interrupt-pending bit is set by a one-cycle `pend_set_i`. A status write with bit 1 = 0 clears it, and a status write with bit 1 = 1 leaves it unchanged. If a set and a clear land on the same edge, the set wins.
- R7: `irq` is high exactly when control bit 6 and the pending bit are both 1.
- R8: A data-register write appears on `tx_byte_o` and raises `dat_wr_o` for one cycle. `rx_load_i` loads `rx_byte_i` into the data register. A bus write on the same edge takes precedence over the load. Reads of 0x95 return the stored byte.
- R9: For a read, the value of the selected register taken on the acknowledge edge is driven on `data_io` while `ack_n` is low. The block never drives `data_io` at any other time.
- R10: While `rst_n` is low, `ack_n` is 1, `irq` is 0, `dat_wr_o` is 0, and the control, own-address, data and pending registers are 0.
- R11: The own-address register is written at 0x8D, appears on `slv_addr_o` and reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 24 | Processor address bus |
| data_io | inout | 8 | Shared processor data bus |
| as_n | input | 1 | Address strobe, active low |
| ds_n | input | 1 | Data strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| ack_n | output | 1 | Transfer acknowledge, active low |
| irq | output | 1 | Interrupt request |
| ctl_o | output | 8 | Control byte to the bit engine |
| slv_addr_o | output | 8 | Own-address byte to the bit engine |
| tx_byte_o | output | 8 | Data byte to the bit engine |
| dat_wr_o | output | 1 | One-cycle pulse on a bus write of the data byte |
| stat_i | input | 8 | Engine status flags, in status-byte bit positions |
| pend_set_i | input | 1 | Engine request to set interrupt pending |
| rx_byte_i | input | 8 | Received byte from the engine |
| rx_load_i | input | 1 | Load strobe for `rx_byte_i` |

## Verification
The processor's write lands on the edge where the acknowledge falls, and the engine can update the same storage on that edge. Two such collisions are provoked on purpose. The first pulses the engine's pending-set on exactly that edge while the processor writes a pending-clear. The second pulses the received-byte load on that edge while the processor writes the data register. In the first case, a later status read and `irq` must show the pending bit still set. In the second, `tx_byte_o` and a later read must show the processor's byte. Both collisions are also combined with reads, where the read must return the value from before the edge and the engine update must show on the next access.

// File: rtl/mpu_reg_port.sv
module mpu_reg_port #(
  parameter logic [15:0] BASE = 16'h0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [23:0] addr_i,
  inout  wire  [7:0]  data_io,
  input  logic        as_n,
  input  logic        ds_n,
  input  logic        rw,
  output logic        ack_n,
  output logic        irq,
  output logic [7:0]  ctl_o,
  output logic [7:0]  slv_addr_o,
  output logic [7:0]  tx_byte_o,
  output logic        dat_wr_o,
  input  logic [7:0]  stat_i,
  input  logic        pend_set_i,
  input  logic [7:0]  rx_byte_i,
  input  logic        rx_load_i
);
  localparam logic [7:0] OFS_ADR  = 8'h8D;
  localparam logic [7:0] OFS_CTL  = 8'h91;
  localparam logic [7:0] OFS_STAT = 8'h93;
  localparam logic [7:0] OFS_DAT  = 8'h95;
  localparam logic [7:0] CTL_MASK = 8'hFC;
  localparam int         PEND_BIT = 1;
  localparam int         IE_BIT   = 6;

  logic [1:0] as_sy, ds_sy;
  logic       busy_q, rd_q, pend_q, oe;
  logic [7:0] rdat_q, ctl_q, adr_q, dat_q, stat_v, rmux;

  wire hit      = (addr_i[23:8] == BASE);
  wire sel_adr  = hit && (addr_i[7:0] == OFS_ADR);
  wire sel_ctl  = hit && (addr_i[7:0] == OFS_CTL);
  wire sel_stat = hit && (addr_i[7:0] == OFS_STAT);
  wire sel_dat  = hit && (addr_i[7:0] == OFS_DAT);
  wire strobed  = !as_sy[1] && !ds_sy[1];
  wire released = as_sy[1] && ds_sy[1];
  wire accept   = !busy_q && strobed;
  wire wr       = accept && !rw;

  assign stat_v = {stat_i[7:4], 1'b0, stat_i[2], pend_q, stat_i[0]};

  always_comb begin
    rmux = 8'h00;
    if (sel_adr)  rmux = adr_q;
    if (sel_ctl)  rmux = ctl_q;
    if (sel_stat) rmux = stat_v;
    if (sel_dat)  rmux = dat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      as_sy <= 2'b11;
      ds_sy <= 2'b11;
    end else begin
      as_sy <= {as_sy[0], as_n};
      ds_sy <= {ds_sy[0], ds_n};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ack_n  <= 1'b1;
      rd_q   <= 1'b0;
      rdat_q <= 8'h00;
    end else if (accept) begin
      busy_q <= 1'b1;
      ack_n  <= 1'b0;
      rd_q   <= rw;
      rdat_q <= rmux;
    end else if (busy_q && released) begin
      busy_q <= 1'b0;
      ack_n  <= 1'b1;
      rd_q   <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= 8'h00;
      adr_q    <= 8'h00;
      dat_q    <= 8'h00;
      pend_q   <= 1'b0;
      dat_wr_o <= 1'b0;
    end else begin
      dat_wr_o <= wr && sel_dat;
      if (wr && sel_ctl) ctl_q <= data_io & CTL_MASK;
      if (wr && sel_adr) adr_q <= data_io;
      if (wr && sel_dat)  dat_q <= data_io;
      else if (rx_load_i) dat_q <= rx_byte_i;
      if (pend_set_i) pend_q <= 1'b1;
      else if (wr && sel_stat && !data_io[PEND_BIT]) pend_q <= 1'b0;
    end
  end

  assign oe         = busy_q && rd_q;
  assign data_io    = oe ? rdat_q : 8'bz;
  assign irq        = ctl_q[IE_BIT] && pend_q;
  assign ctl_o      = ctl_q;
  assign slv_addr_o = adr_q;
  assign tx_byte_o  = dat_q;
endmodule

module mpu_reg_port_chk (
  input logic clk,
  input logic rst_n,
  input logic as_n,
  input logic ds_n,
  input logic ack_n,
  input logic irq,
  input logic ctl_ie,
  input logic dat_wr_o,
  input logic pend_set_i,
  input logic pend_q,
  input logic oe
);
  a_r2_ack_after_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) |-> (!$past(as_n, 2) && !$past(ds_n, 2)));
  a_r3_write_on_ack_edge: assert property (@(posedge clk) disable iff (!rst_n)
    dat_wr_o |-> $fell(ack_n));
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dat_wr_o |=> !dat_wr_o);
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    pend_set_i |=> pend_q);
  a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_ie |-> !irq);
  a_r9_drive_only_acked: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> !ack_n);
endmodule

bind mpu_reg_port mpu_reg_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .as_n(as_n), .ds_n(ds_n), .ack_n(ack_n),
  .irq(irq), .ctl_ie(ctl_o[6]), .dat_wr_o(dat_wr_o),
  .pend_set_i(pend_set_i), .pend_q(pend_q), .oe(oe)
);

// File: tb/mpu_reg_port_test.sv
module mpu_reg_port_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic [23:0] addr;
  logic        as_n, ds_n, rw, drv;
  logic [7:0]  dval;
  wire  [7:0]  dbus;
  logic        ack_n, irq, dat_wr_o;
  logic [7:0]  ctl_o, slv_addr_o, tx_byte_o;
  logic [7:0]  stat_i, rx_byte_i;
  logic        pend_set_i, rx_load_i;

  assign dbus = drv ? dval : 8'bz;

  mpu_reg_port uut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .data_io(dbus), .as_n(as_n),
    .ds_n(ds_n), .rw(rw), .ack_n(ack_n), .irq(irq), .ctl_o(ctl_o),
    .slv_addr_o(slv_addr_o), .tx_byte_o(tx_byte_o), .dat_wr_o(dat_wr_o),
    .stat_i(stat_i), .pend_set_i(pend_set_i), .rx_byte_i(rx_byte_i),
    .rx_load_i(rx_load_i)
  );

  int   vecs = 0;
  int   errs = 0;
  logic timeout = 1'b0;
  logic [7:0] m_ctl, m_adr, m_dat;
  logic       m_pend;

  function automatic logic [7:0] f_stat(input logic [7:0] s, input logic p);
    return {s[7:4], 1'b0, s[2], p, s[0]};
  endfunction

  function automatic logic [7:0] f_read(input logic [23:0] a);
    if (a[23:8] != 16'h0000) return 8'h00;
    case (a[7:0])
      8'h8D:   return m_adr;
      8'h91:   return m_ctl;
      8'h93:   return f_stat(stat_i, m_pend);
      8'h95:   return m_dat;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // col: 0 none, 1 pending-set on the acknowledge edge, 2 receive-load on that edge
  task automatic op(input logic [23:0] a, input logic r, input logic [7:0] wd,
                    input int col, input logic [7:0] rxb);
    logic [7:0] exp_rd, got;
    logic       is_dat_wr;
    exp_rd    = f_read(a);
    is_dat_wr = !r && (a == 24'h000095);
    @(negedge clk);
    addr = a; rw = r; as_n = 1'b0; ds_n = 1'b0; drv = !r; dval = wd;
    @(negedge clk);
    chk("R2 ack early 1", {7'b0, ack_n}, 8'h01);
    @(negedge clk);
    chk("R2 ack early 2", {7'b0, ack_n}, 8'h01);
    if (col == 1) pend_set_i = 1'b1;
    if (col == 2) begin rx_load_i = 1'b1; rx_byte_i = rxb; end
    @(negedge clk);
    pend_set_i = 1'b0; rx_load_i = 1'b0;
    chk("R2 ack low", {7'b0, ack_n}, 8'h00);
    chk("R8 R3 data write strobe", {7'b0, dat_wr_o}, {7'b0, is_dat_wr});
    got = dbus;
    if (r) chk("R9 R1 R5 read data", got, exp_rd);
    as_n = 1'b1; ds_n = 1'b1; drv = 1'b0;
    @(negedge clk);
    chk("R2 ack held 1", {7'b0, ack_n}, 8'h00);
    chk("R8 strobe one cycle", {7'b0, dat_wr_o}, 8'h00);
    @(negedge clk);
    chk("R2 ack held 2", {7'b0, ack_n}, 8'h00);
    @(negedge clk);
    chk("R2 ack released", {7'b0, ack_n}, 8'h01);
    if (!r && a[23:8] == 16'h0000) begin
      if (a[7:0] == 8'h91) m_ctl = wd & 8'hFC;
      if (a[7:0] == 8'h8D) m_adr = wd;
      if (a[7:0] == 8'h93 && !wd[1]) m_pend = 1'b0;
    end
    if (col == 1) m_pend = 1'b1;
    if (col == 2) m_dat = rxb;
    if (is_dat_wr) m_dat = wd;
    chk("R4 ctl_o", ctl_o, m_ctl);
    chk("R11 slv_addr_o", slv_addr_o, m_adr);
    chk("R8 tx_byte_o", tx_byte_o, m_dat);
    chk("R7 irq", {7'b0, irq}, {7'b0, m_ctl[6] & m_pend});
  endtask

  task automatic engine_pulse(input logic pend, input logic load, input logic [7:0] b);
    @(negedge clk);
    pend_set_i = pend; rx_load_i = load; rx_byte_i = b;
    @(negedge clk);
    pend_set_i = 1'b0; rx_load_i = 1'b0;
    if (pend) m_pend = 1'b1;
    if (load) m_dat = b;
  endtask

  task automatic run();
    logic [23:0] a;
    logic [7:0]  lo;
    int          k;
    rst_n = 1'b0; as_n = 1'b1; ds_n = 1'b1; rw = 1'b1; drv = 1'b0; dval = 8'h00;
    addr = 24'h0; stat_i = 8'h00; pend_set_i = 1'b0; rx_load_i = 1'b0; rx_byte_i = 8'h00;
    m_ctl = 8'h00; m_adr = 8'h00; m_dat = 8'h00; m_pend = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 ack_n in reset", {7'b0, ack_n}, 8'h01);
    chk("R10 irq in reset", {7'b0, irq}, 8'h00);
    chk("R10 ctl_o in reset", ctl_o, 8'h00);
    chk("R10 data in reset", tx_byte_o, 8'h00);
    chk("R10 strobe in reset", {7'b0, dat_wr_o}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corner cases
    op(24'h000091, 1'b0, 8'hFF, 0, 8'h00);        // R4 reserved bits dropped
    op(24'h000091, 1'b1, 8'h00, 0, 8'h00);
    op(24'h00008D, 1'b0, 8'hA4, 0, 8'h00);        // R11
    op(24'h00008D, 1'b1, 8'h00, 0, 8'h00);
    op(24'h010091, 1'b0, 8'h00, 0, 8'h00);        // R1 base mismatch ignored
    op(24'h000097, 1'b0, 8'h5A, 0, 8'h00);        // R1 unmapped write
    op(24'h000097, 1'b1, 8'h00, 0, 8'h00);        // R1 unmapped read zero
    stat_i = 8'hFF;
    op(24'h000093, 1'b1, 8'h00, 0, 8'h00);        // R5 reserved reads zero
    op(24'h000093, 1'b0, 8'h00, 0, 8'h00);        // R5 flags unaffected
    op(24'h000093, 1'b1, 8'h00, 0, 8'h00);
    engine_pulse(1'b1, 1'b0, 8'h00);
    op(24'h000093, 1'b0, 8'h02, 0, 8'h00);        // R6 bit1=1 keeps pending
    op(24'h000093, 1'b1, 8'h00, 0, 8'h00);
    op(24'h000093, 1'b0, 8'h00, 1, 8'h00);        // R6 set beats clear on same edge
    op(24'h000093, 1'b1, 8'h00, 0, 8'h00);
    op(24'h000095, 1'b0, 8'h3C, 2, 8'hC3);        // R8 bus write beats load
    op(24'h000095, 1'b1, 8'h00, 0, 8'h00);
    op(24'h000095, 1'b1, 8'h00, 2, 8'h81);        // R8 load during read: old value read
    op(24'h000095, 1'b1, 8'h00, 0, 8'h00);
    // R9: bus floats between accesses
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      drv = 1'b1; dval = 8'h11 << i;
      @(negedge clk);
      chk("R9 bus released when idle", dbus, 8'h11 << i);
      drv = 1'b0;
    end

    // constrained random
    for (int i = 0; i < 400; i++) begin
      stat_i = 8'($urandom);
      k = $urandom_range(0, 9);
      case ($urandom_range(0, 5))
        0: lo = 8'h8D;
        1: lo = 8'h91;
        2: lo = 8'h93;
        3: lo = 8'h95;
        4: lo = 8'h95;
        default: lo = 8'($urandom);
      endcase
      a = {($urandom_range(0, 7) == 0) ? 16'($urandom_range(1, 65535)) : 16'h0000, lo};
      if (k == 0) engine_pulse(1'b1, 1'b0, 8'h00);
      if (k == 1) engine_pulse(1'b0, 1'b1, 8'($urandom));
      op(a, 1'($urandom), 8'($urandom),
         ($urandom_range(0, 5) == 0) ? $urandom_range(1, 2) : 0, 8'($urandom));
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    fork
      run();
      begin
        repeat (150000) @(posedge clk);
        timeout = 1'b1;
      end
    join_any
    disable fork;
    if (timeout) begin
      vecs++;
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule